// File: doc/BRIEF.md
# Single-Slot Lossy Channel Stage

This block is a one-place transport medium that sits between two protocol agents. It has an input slot, which the producer fills, and an output slot, which the consumer drains. Each slot holds a 2-bit tag and an optional payload. In any cycle where the output slot is empty and the input slot holds a frame, the block moves that frame across and frees the input slot. The move takes one clock edge.

During that move an external corruption input can replace the forwarded tag with the error code. A test environment uses this input to inject loss and damage on the link. The payload width is a parameter. With a width of zero, the same block carries the acknowledgement direction, which has tags only.

The tag encoding is fixed: 0 means empty, 1 is a frame carrying bit 0, 2 is a frame carrying bit 1, and 3 is the error code. A slot counts as occupied when its tag is not 0.

Top module: `lossy_slot_stage`

## Requirements
- R1: After reset both slots are empty. `out_tag` reads 0, `in_ready` reads 1 and `out_data` reads 0. Reset is asserted asynchronously and takes effect at once, even while frames are held.
- R2: A write (`in_wr` = 1) is stored only if the input slot is empty (`in_ready` = 1) and `in_tag` is not 0. Any other write is ignored and leaves the held frame unchanged.
- R3: A transfer happens only when the output slot is empty and the input slot is occupied. While the output slot is occupied, a waiting frame stays in the input slot and `in_ready` stays 0.
- R4: A transfer with `corrupt_en` = 0 makes `out_tag` equal to the stored tag. On the same edge it empties the input slot, so `in_ready` returns to 1.
- R5: A transfer with `corrupt_en` = 1 in that cycle sets `out_tag` to the error code 3.
- R6: On a transfer the stored payload is copied unchanged to `out_data`. This holds whether or not the tag is corrupted. `out_data` keeps its value after the slot is drained.
- R7: `out_take` = 1 empties an occupied output slot on the next edge. On an empty output slot it has no effect.
- R8: A write made in a cycle where a transfer takes place is ignored, because the input slot is still occupied in that cycle.
- R9: If no transfer occurs, the output slot keeps its tag and payload until it is taken.
- R10: With `DATA_W` = 0, tags pass through and can be corrupted exactly as with a payload, and `out_data` reads 0.
- R11: `corrupt_en` has no effect in a cycle without a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_wr | input | 1 | Producer write strobe |
| in_tag | input | 2 | Tag to write (0 empty, 1 bit-0 frame, 2 bit-1 frame, 3 error) |
| in_data | input | PW | Payload to write (PW = DATA_W, or 1 when DATA_W = 0) |
| in_ready | output | 1 | Input slot empty |
| corrupt_en | input | 1 | Replace the forwarded tag with the error code on a transfer |
| out_take | input | 1 | Consumer drains the output slot |
| out_tag | output | 2 | Output slot tag |
| out_data | output | PW | Output slot payload (0 when DATA_W = 0) |

## Verification
Several functions can meet in a single cycle. A producer write can arrive in the same cycle that the pending frame crosses over. A consumer drain can coincide with a new producer write. Corruption can be asserted in a cycle with no transfer. The vector table drives each of these pairs on one edge. It then checks the slot contents after that edge and again one edge later, to show that the dropped write really did vanish and that the drained slot fills from the new frame.

// File: rtl/lss_pkg.sv
package lss_pkg;
  typedef enum logic [1:0] {
    TAG_EMPTY = 2'd0,
    TAG_BIT0  = 2'd1,
    TAG_BIT1  = 2'd2,
    TAG_ERR   = 2'd3
  } lss_tag_e;

  localparam int TAG_W = 2;
endpackage

// File: rtl/lss_rst_sync.sv
module lss_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/lss_slot.sv
module lss_slot
  import lss_pkg::*;
#(
  parameter int PW       = 8,
  parameter bit HAS_DATA = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clear,
  input  logic [TAG_W-1:0] ld_tag,
  input  logic [PW-1:0]    ld_data,
  output logic [TAG_W-1:0] tag,
  output logic [PW-1:0]    data
);
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             tag_en;

  // load has priority; the controller never raises both
  always_comb begin
    tag_en = load | clear;
    tag_d  = load ? ld_tag : TAG_EMPTY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tag_q <= TAG_EMPTY;
    else if (tag_en) tag_q <= tag_d;
  end

  assign tag = tag_q;

  generate
    if (HAS_DATA) begin : g_payload
      logic [PW-1:0] data_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    data_q <= '0;
        else if (load) data_q <= ld_data;
      end
      assign data = data_q;
    end else begin : g_no_payload
      logic unused_ok;
      assign unused_ok = ^ld_data;
      assign data      = '0;
    end
  endgenerate
endmodule

// File: rtl/lss_xfer_ctrl.sv
module lss_xfer_ctrl
  import lss_pkg::*;
(
  input  logic [TAG_W-1:0] in_slot_tag,
  input  logic [TAG_W-1:0] out_slot_tag,
  input  logic             wr_req,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             take_req,
  input  logic             corrupt,
  output logic             wr_ok,
  output logic             take_ok,
  output logic             xfer,
  output logic [TAG_W-1:0] fwd_tag
);
  logic in_full, out_full;

  always_comb begin
    in_full  = (in_slot_tag  != TAG_EMPTY);
    out_full = (out_slot_tag != TAG_EMPTY);
    xfer     = in_full & ~out_full;
    wr_ok    = wr_req & ~in_full & (wr_tag != TAG_EMPTY);
    take_ok  = take_req & out_full;
    fwd_tag  = corrupt ? TAG_ERR : in_slot_tag;
  end
endmodule

// File: rtl/lossy_slot_stage.sv
module lossy_slot_stage
  import lss_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int PW     = (DATA_W > 0) ? DATA_W : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_wr,
  input  logic [1:0]    in_tag,
  input  logic [PW-1:0] in_data,
  output logic          in_ready,
  input  logic          corrupt_en,
  input  logic          out_take,
  output logic [1:0]    out_tag,
  output logic [PW-1:0] out_data
);
  localparam bit HAS_DATA = (DATA_W > 0);

  logic             rst_q_n;
  logic             wr_ok, take_ok, xfer;
  logic [TAG_W-1:0] in_slot_tag, out_slot_tag, fwd_tag;
  logic [PW-1:0]    in_slot_data, out_slot_data;

  lss_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  lss_xfer_ctrl u_ctrl (
    .in_slot_tag(in_slot_tag), .out_slot_tag(out_slot_tag),
    .wr_req(in_wr), .wr_tag(in_tag), .take_req(out_take),
    .corrupt(corrupt_en), .wr_ok(wr_ok), .take_ok(take_ok),
    .xfer(xfer), .fwd_tag(fwd_tag)
  );

  lss_slot #(.PW(PW), .HAS_DATA(HAS_DATA)) u_in_slot (
    .clk(clk), .rst_n(rst_q_n), .load(wr_ok), .clear(xfer),
    .ld_tag(in_tag), .ld_data(in_data),
    .tag(in_slot_tag), .data(in_slot_data)
  );

  lss_slot #(.PW(PW), .HAS_DATA(HAS_DATA)) u_out_slot (
    .clk(clk), .rst_n(rst_q_n), .load(xfer), .clear(take_ok),
    .ld_tag(fwd_tag), .ld_data(in_slot_data),
    .tag(out_slot_tag), .data(out_slot_data)
  );

  assign in_ready = (in_slot_tag == TAG_EMPTY);
  assign out_tag  = out_slot_tag;
  assign out_data = out_slot_data;
endmodule

// File: rtl/lss_checker.sv
module lss_checker #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_wr,
  input logic [1:0]    in_tag,
  input logic          in_ready,
  input logic          corrupt_en,
  input logic          out_take,
  input logic [1:0]    out_tag,
  input logic [PW-1:0] out_data
);
  // R2: an accepted write occupies the input slot
  p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_wr && in_tag != 2'd0) |=> !in_ready);

  // R3: the output only fills from an occupied input slot
  p_fill_needs_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tag == 2'd0 && in_ready) |=> (out_tag == 2'd0));

  // R4: a clean transfer forwards a frame tag and frees the input
  p_clean_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tag == 2'd0 && !in_ready && !corrupt_en) |=> (out_tag != 2'd0 && in_ready));

  // R5: corruption during a transfer yields the error code
  p_corrupt_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tag == 2'd0 && !in_ready && corrupt_en) |=> (out_tag == 2'd3 && in_ready));

  // R7: taking an occupied output empties it
  p_take_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tag != 2'd0 && out_take) |=> (out_tag == 2'd0));

  // R9: an untaken output keeps tag and payload
  p_out_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tag != 2'd0 && !out_take) |=> ($stable(out_tag) && $stable(out_data)));
endmodule

bind lossy_slot_stage lss_checker #(.PW(PW)) u_lss_chk (
  .clk(clk), .rst_n(rst_q_n), .in_wr(in_wr), .in_tag(in_tag),
  .in_ready(in_ready), .corrupt_en(corrupt_en), .out_take(out_take),
  .out_tag(out_tag), .out_data(out_data)
);

// File: tb/lossy_slot_stage_bench.sv
module lossy_slot_stage_bench;
  localparam int CLK_P = 10;
  localparam int NVEC  = 14;

  // {req(4), wr, wtag(2), wdata(8), take, corr, etag(2), edata(8), erdy}
  localparam logic [27:0] VEC [NVEC] = '{
    {4'd4,  1'b1, 2'd1, 8'hA5, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0}, // R2 write
    {4'd4,  1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd1, 8'hA5, 1'b1}, // R4 R6 transfer
    {4'd3,  1'b1, 2'd2, 8'h3C, 1'b0, 1'b0, 2'd1, 8'hA5, 1'b0}, // R3 blocked
    {4'd2,  1'b1, 2'd1, 8'hFF, 1'b0, 1'b0, 2'd1, 8'hA5, 1'b0}, // R2 write to full ignored
    {4'd11, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 2'd1, 8'hA5, 1'b0}, // R11 R9
    {4'd7,  1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0, 8'hA5, 1'b0}, // R7 R6 data kept
    {4'd2,  1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd2, 8'h3C, 1'b1}, // R2 first frame kept
    {4'd7,  1'b1, 2'd1, 8'h11, 1'b1, 1'b0, 2'd0, 8'h3C, 1'b0}, // R7 take+write
    {4'd5,  1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 2'd3, 8'h11, 1'b1}, // R5 R6 corrupt
    {4'd2,  1'b1, 2'd0, 8'h77, 1'b1, 1'b0, 2'd0, 8'h11, 1'b1}, // R2 empty tag ignored
    {4'd7,  1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0, 8'h11, 1'b1}, // R7 take on empty
    {4'd2,  1'b1, 2'd2, 8'h42, 1'b0, 1'b0, 2'd0, 8'h11, 1'b0}, // R2
    {4'd8,  1'b1, 2'd1, 8'h99, 1'b0, 1'b0, 2'd2, 8'h42, 1'b1}, // R8 write in xfer cycle
    {4'd8,  1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd2, 8'h42, 1'b1}  // R8 write dropped
  };

  logic       clk, rst_n;
  logic       in_wr, corrupt_en, out_take, in_ready;
  logic [1:0] in_tag, out_tag;
  logic [7:0] in_data, out_data;
  logic       a_wr, a_corrupt, a_take, a_ready;
  logic [1:0] a_tag, a_out_tag;
  logic [0:0] a_out_data;
  int total, bad;
  bit done;

  lossy_slot_stage #(.DATA_W(8)) u_lossy_slot_stage (
    .clk(clk), .rst_n(rst_n), .in_wr(in_wr), .in_tag(in_tag),
    .in_data(in_data), .in_ready(in_ready), .corrupt_en(corrupt_en),
    .out_take(out_take), .out_tag(out_tag), .out_data(out_data)
  );

  lossy_slot_stage #(.DATA_W(0)) u_ack_stage (
    .clk(clk), .rst_n(rst_n), .in_wr(a_wr), .in_tag(a_tag),
    .in_data(1'b0), .in_ready(a_ready), .corrupt_en(a_corrupt),
    .out_take(a_take), .out_tag(a_out_tag), .out_data(a_out_data)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_wr = 0; in_tag = 0; in_data = 0; corrupt_en = 0; out_take = 0;
    a_wr = 0; a_tag = 0; a_corrupt = 0; a_take = 0;
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "out_tag", out_tag, 0);
    check("R1", "in_ready", in_ready, 1);
    check("R1", "out_data", out_data, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [27:0] v;
      string rq;
      v = VEC[i];
      in_wr = v[23]; in_tag = v[22:21]; in_data = v[20:13];
      out_take = v[12]; corrupt_en = v[11];
      @(negedge clk);
      rq = $sformatf("R%0d", v[27:24]);
      check(rq, $sformatf("v%0d out_tag", i), out_tag, v[10:9]);
      check(rq, $sformatf("v%0d out_data", i), out_data, v[8:1]);
      check(rq, $sformatf("v%0d in_ready", i), in_ready, v[0]);
      idle_inputs();
    end

    // R10 tag-only variant: clean then corrupted transfer
    a_wr = 1; a_tag = 2'd2;
    @(negedge clk); idle_inputs();
    @(negedge clk);
    check("R10", "ack out_tag", a_out_tag, 2);
    check("R10", "ack out_data", a_out_data, 0);
    a_take = 1; a_wr = 1; a_tag = 2'd1;
    @(negedge clk); idle_inputs(); a_corrupt = 1;
    @(negedge clk); idle_inputs();
    check("R10", "ack corrupted tag", a_out_tag, 3);
    check("R10", "ack in_ready", a_ready, 1);

    // R1 asynchronous reset with both slots occupied
    in_take_full();
    rst_n = 0;
    #1;
    check("R1", "async out_tag", out_tag, 0);
    check("R1", "async in_ready", in_ready, 1);
    check("R1", "async out_data", out_data, 0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1", "post-reset out_tag", out_tag, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // fill output slot, then input slot (drains any leftover first)
  task automatic in_take_full();
    out_take = 1; @(negedge clk); idle_inputs();
    out_take = 1; @(negedge clk); idle_inputs();
    in_wr = 1; in_tag = 2'd1; in_data = 8'h5A; @(negedge clk); idle_inputs();
    @(negedge clk);
    in_wr = 1; in_tag = 2'd2; in_data = 8'h6B; @(negedge clk); idle_inputs();
    check("R3", "both full out_tag", out_tag, 1);
    check("R3", "both full in_ready", in_ready, 0);
  endtask
endmodule